// File: doc/BRIEF.md
# GPU Register Window with Doorbell

This block is a bus slave that sits in front of the command-processor register space of a GPU. It checks each bus address against a fixed 64 KiB window. Inside the window, bits [15:2] select a 32-bit word register. Five registers are implemented. The rest of the window reads as zero, and writes to it are discarded.

The host writes the ring-buffer write pointer, and each such write also rings a doorbell. The doorbell is a one-cycle pulse to the command-processor consumer. A sticky pending-wake flag backs the pulse and holds until the consumer acknowledges it.

Two registers are read-only from the bus and show values supplied by the GPU: the ring read pointer and the interrupt status. The interrupt-acknowledge register returns the last value written to it. The vertical-blank status register collects per-bit events from display logic, and software clears its bits by writing ones.

Top module: `gpu_reg_window`

## Requirements
- R1: An access reaches the window only when (bus_addr & 0xFFFF0000) == 0x7FC80000. An access outside the window changes no register and returns zero read data.
- R2: The write pointer at byte offset 0x0714 stores all 32 bits of a bus write. It reads back the stored value and drives it on wptr_out. Reset clears it to zero.
- R3: doorbell is high for exactly the one clock cycle that follows each clock edge at which a write-pointer write was accepted. It stays low in every other cycle.
- R4: wake_pending rises with the doorbell and stays high until wake_ack is sampled high. A doorbell in the same cycle as wake_ack leaves the flag set.
- R5: The interrupt-acknowledge register at byte offset 0x07D0 stores a bus write unchanged and returns the last written value.
- R6: The ring read pointer (offset 0x0710) returns ring_rptr_in on a read. The interrupt status (offset 0x07C4) returns irq_status_in on a read. Bus writes to either register have no effect.
- R7: In the vblank status register (offset 0x0E80, low VB_W bits), each written 1 clears that bit and each written 0 leaves it unchanged. With 0b11 stored, writing 0b01 leaves 0b10, and writing 0 then leaves 0b10.
- R8: A high bit of vblank_set sets the matching status bit at the next edge. When a set and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: A read of an unimplemented offset inside the window returns zero. A write to one changes no register and raises no doorbell.
- R10: bus_rdata is registered. It carries the addressed value in the cycle after a read is accepted, and it is zero in the cycle after any cycle with no accepted read.
- R11: An active-low synchronous reset clears the write pointer, the acknowledge register, the vblank status, the doorbell, wake_pending and bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_vld | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ring_rptr_in | input | 32 | Ring read pointer from the command processor |
| irq_status_in | input | 32 | Interrupt status from the interrupt logic |
| vblank_set | input | VB_W | Per-bit set events from display timing |
| wake_ack | input | 1 | Consumer clears the pending wake |
| wptr_out | output | 32 | Current ring write pointer |
| doorbell | output | 1 | One-cycle wake pulse |
| wake_pending | output | 1 | Sticky wake flag |

## Verification
The assertions check the doorbell and the wake flag on every cycle. The doorbell must follow an accepted write-pointer write by exactly one edge, the flag must cover every pulse, and the flag must hold until an acknowledge. The assertions also check that vblank set events land in the status, that the write pointer holds when it is not written, and that read data is zero after idle or out-of-window cycles. Only the bench scenarios can show that stored values come back intact through the read path, that the write-one-to-clear arithmetic is right, that set wins over clear on one bit, and that writes to read-only or unimplemented offsets leave nothing behind.

// File: rtl/gpu_reg_window.sv
module gpu_reg_window #(
  parameter logic [31:0] APER_BASE = 32'h7FC8_0000,
  parameter logic [31:0] APER_MASK = 32'hFFFF_0000,
  parameter logic [15:0] OFF_WPTR  = 16'h0714,
  parameter logic [15:0] OFF_RPTR  = 16'h0710,
  parameter logic [15:0] OFF_ISTAT = 16'h07C4,
  parameter logic [15:0] OFF_IACK  = 16'h07D0,
  parameter logic [15:0] OFF_VBLK  = 16'h0E80,
  parameter int          VB_W      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_vld,
  input  logic            bus_we,
  input  logic [31:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [31:0]     ring_rptr_in,
  input  logic [31:0]     irq_status_in,
  input  logic [VB_W-1:0] vblank_set,
  input  logic            wake_ack,
  output logic [31:0]     wptr_out,
  output logic            doorbell,
  output logic            wake_pending
);
  localparam int IW = 14;
  localparam logic [IW-1:0] I_WPTR  = OFF_WPTR[15:2];
  localparam logic [IW-1:0] I_RPTR  = OFF_RPTR[15:2];
  localparam logic [IW-1:0] I_ISTAT = OFF_ISTAT[15:2];
  localparam logic [IW-1:0] I_IACK  = OFF_IACK[15:2];
  localparam logic [IW-1:0] I_VBLK  = OFF_VBLK[15:2];

  logic [31:0]     wptr_q, iack_q, rd_mux;
  logic [VB_W-1:0] vb_q, vb_clr;

  wire in_win = (bus_addr & APER_MASK) == APER_BASE;
  wire [IW-1:0] idx = bus_addr[15:2];
  wire wr = bus_vld & bus_we & in_win;
  wire rd = bus_vld & ~bus_we & in_win;
  wire wr_wptr = wr && idx == I_WPTR;
  wire wr_iack = wr && idx == I_IACK;
  wire wr_vblk = wr && idx == I_VBLK;

  assign vb_clr = wr_vblk ? bus_wdata[VB_W-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (idx == I_WPTR)       rd_mux = wptr_q;
    else if (idx == I_RPTR)  rd_mux = ring_rptr_in;
    else if (idx == I_ISTAT) rd_mux = irq_status_in;
    else if (idx == I_IACK)  rd_mux = iack_q;
    else if (idx == I_VBLK)  rd_mux = 32'(vb_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q       <= '0;
      iack_q       <= '0;
      vb_q         <= '0;
      doorbell     <= 1'b0;
      wake_pending <= 1'b0;
      bus_rdata    <= '0;
    end else begin
      if (wr_wptr) wptr_q <= bus_wdata;
      if (wr_iack) iack_q <= bus_wdata;
      vb_q         <= (vb_q & ~vb_clr) | vblank_set;
      doorbell     <= wr_wptr;
      wake_pending <= (wake_pending & ~wake_ack) | wr_wptr;
      bus_rdata    <= rd ? rd_mux : '0;
    end
  end

  assign wptr_out = wptr_q;
endmodule

// File: rtl/gpu_reg_window_chk.sv
module gpu_reg_window_chk #(
  parameter logic [31:0] APER_BASE = 32'h7FC8_0000,
  parameter logic [31:0] APER_MASK = 32'hFFFF_0000,
  parameter logic [15:0] OFF_WPTR  = 16'h0714,
  parameter int          VB_W      = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_vld,
  input logic            bus_we,
  input logic [31:0]     bus_addr,
  input logic [31:0]     bus_rdata,
  input logic [VB_W-1:0] vblank_set,
  input logic [VB_W-1:0] vb_q,
  input logic            wake_ack,
  input logic [31:0]     wptr_out,
  input logic            doorbell,
  input logic            wake_pending
);
  wire hit_wptr = bus_vld && bus_we && ((bus_addr & APER_MASK) == APER_BASE)
                  && bus_addr[15:2] == OFF_WPTR[15:2];
  wire miss_rd  = bus_vld && !bus_we && ((bus_addr & APER_MASK) != APER_BASE);

  // R3
  doorbell_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wptr |=> doorbell);
  // R3
  doorbell_only_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_wptr |=> !doorbell);
  // R4
  pending_covers_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> wake_pending);
  // R4
  pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pending && !wake_ack) |=> wake_pending);
  // R2
  wptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_wptr |=> $stable(wptr_out));
  // R8
  vblank_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_set != '0) |=> ((vb_q & $past(vblank_set)) == $past(vblank_set)));
  // R1
  outside_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_rd |=> bus_rdata == '0);
  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld |=> bus_rdata == '0);
endmodule

bind gpu_reg_window gpu_reg_window_chk #(
  .APER_BASE(APER_BASE), .APER_MASK(APER_MASK), .OFF_WPTR(OFF_WPTR), .VB_W(VB_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .vblank_set(vblank_set),
  .vb_q(vb_q), .wake_ack(wake_ack), .wptr_out(wptr_out),
  .doorbell(doorbell), .wake_pending(wake_pending)
);

// File: tb/gpu_reg_window_test.sv
module gpu_reg_window_test;
  localparam time CLK_P = 10ns;
  localparam int  VB_W  = 8;
  localparam logic [31:0] B = 32'h7FC8_0000;

  logic clk = 0, rst_n = 0, bus_vld = 0, bus_we = 0, wake_ack = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, ring_rptr_in = 0, irq_status_in = 0;
  logic [VB_W-1:0] vblank_set = 0;
  logic [31:0] bus_rdata, wptr_out;
  logic doorbell, wake_pending;
  int n_run = 0, n_fail = 0;
  logic rd_seen = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  gpu_reg_window #(.VB_W(VB_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ring_rptr_in(ring_rptr_in), .irq_status_in(irq_status_in),
    .vblank_set(vblank_set), .wake_ack(wake_ack), .wptr_out(wptr_out),
    .doorbell(doorbell), .wake_pending(wake_pending)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_vld && !bus_we;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0)
      check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic rd(logic [31:0] a, logic [31:0] e, string tag);
    @(negedge clk); #1;
    bus_vld = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); #1;
    bus_vld = 0;
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d,
                    logic [VB_W-1:0] setv = '0, logic ack = 0);
    @(negedge clk); #1;
    bus_vld = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    vblank_set = setv; wake_ack = ack;
    @(negedge clk); #1;
    bus_vld = 0; bus_we = 0; vblank_set = '0; wake_ack = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got %h expected %h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R11 reset state
    check("R11 rdata", bus_rdata, 0);
    check("R11 doorbell", 32'(doorbell), 0);
    check("R11 pending", 32'(wake_pending), 0);
    check("R11 wptr_out", wptr_out, 0);
    rd(B + 32'h0714, 0, "R11 wptr read");
    rd(B + 32'h07D0, 0, "R11 iack read");
    rd(B + 32'h0E80, 0, "R11 vblank read");
    // R2 / R3 / R4
    wr(B + 32'h0714, 32'h1234_5678);
    check("R3 doorbell high", 32'(doorbell), 1);
    check("R4 pending set", 32'(wake_pending), 1);
    check("R2 wptr_out", wptr_out, 32'h1234_5678);
    idle(1);
    check("R3 doorbell one cycle", 32'(doorbell), 0);
    idle(3);
    check("R4 pending held", 32'(wake_pending), 1);
    rd(B + 32'h0714, 32'h1234_5678, "R2 wptr readback");
    @(negedge clk); #1 wake_ack = 1;
    @(negedge clk); #1 wake_ack = 0;
    check("R4 pending cleared", 32'(wake_pending), 0);
    wr(B + 32'h0714, 32'hFFFF_0001, '0, 1'b1);
    check("R4 set beats ack", 32'(wake_pending), 1);
    @(negedge clk); #1 wake_ack = 1;
    @(negedge clk); #1 wake_ack = 0;
    // R5
    wr(B + 32'h07D0, 32'hDEAD_BEEF);
    rd(B + 32'h07D0, 32'hDEAD_BEEF, "R5 iack echo");
    // R6
    ring_rptr_in = 32'hCAFE_F00D; irq_status_in = 32'h0000_0001;
    rd(B + 32'h0710, 32'hCAFE_F00D, "R6 rptr read");
    rd(B + 32'h07C4, 32'h0000_0001, "R6 istat read");
    wr(B + 32'h0710, 32'h0);
    wr(B + 32'h07C4, 32'hFFFF_FFFF);
    rd(B + 32'h0710, 32'hCAFE_F00D, "R6 rptr after write");
    rd(B + 32'h07C4, 32'h0000_0001, "R6 istat after write");
    // R8 / R7
    @(negedge clk); #1 vblank_set = 8'b11;
    @(negedge clk); #1 vblank_set = 0;
    rd(B + 32'h0E80, 32'h3, "R8 set lands");
    wr(B + 32'h0E80, 32'h1);
    rd(B + 32'h0E80, 32'h2, "R7 w1c bit0");
    wr(B + 32'h0E80, 32'h0);
    rd(B + 32'h0E80, 32'h2, "R7 write zero no-op");
    wr(B + 32'h0E80, 32'h1, 8'h01);
    rd(B + 32'h0E80, 32'h3, "R8 set wins over clear");
    // R9
    wr(B + 32'h0100, 32'hFFFF_FFFF);
    check("R9 no doorbell", 32'(doorbell), 0);
    rd(B + 32'h0100, 0, "R9 unmapped read");
    rd(B + 32'h0714, 32'hFFFF_0001, "R9 wptr untouched");
    // R1
    wr(32'h7FC9_0714, 32'h0000_0055);
    check("R1 outside no doorbell", 32'(doorbell), 0);
    check("R1 outside wptr_out", wptr_out, 32'hFFFF_0001);
    rd(32'h7FC9_0714, 0, "R1 outside read zero");
    rd(32'h0000_07D0, 0, "R1 low address read zero");
    // R10
    idle(2);
    check("R10 idle rdata zero", bus_rdata, 0);
    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule